// File: doc/BRIEF.md
# System Handler Control and Status Register

This block is the control and status word for a processor's configurable system exceptions. It covers the memory-management fault, bus fault, usage fault, supervisor call, debug monitor, PendSV and SysTick. It keeps three groups of flags:

- an enable flag for each of the three configurable faults;
- a pending flag for each of the three faults and for the supervisor call;
- an active flag for all seven handlers.

The exception logic sets and clears these flags through event inputs. Privileged software reads and writes the same word over a single-cycle register port. When hardware and software both touch a flag in the same cycle, the two are merged.

The block also routes fault requests. A configurable fault raised while its enable flag is set goes out on its own request line. If the enable flag is clear, the fault is escalated to the hard-fault request instead. Prioritisation, stacking, vector fetch and fault-status reporting are left to the surrounding exception logic, which reads the enable, pending and active vectors straight from the outputs.

Handler index used on all vector ports: 0 memory-management fault, 1 bus fault, 2 usage fault, 3 supervisor call, 4 debug monitor, 5 PendSV, 6 SysTick. Pending vectors use indices 0 to 3, and enable and fault vectors use indices 0 to 2.

Top module: `sys_handler_ctrl`

## Requirements
- R1: A synchronous reset clears every enable, pending and active flag and both request outputs, so a read returns 0x0000_0000.
- R2: The word layout is fixed. Enables sit at bit 16 (memory), bit 17 (bus) and bit 18 (usage). Pending flags sit at bit 12 (usage), bit 13 (memory), bit 14 (bus) and bit 15 (supervisor call). Active flags sit at bit 0 (memory), bit 1 (bus), bit 3 (usage), bit 7 (supervisor call), bit 8 (debug monitor), bit 10 (PendSV) and bit 11 (SysTick). The en_vec, pend_vec and act_vec outputs mirror these flags.
- R3: A fault raised while its enable flag is 1 drives its own fault_req bit high on the clock edge that samples the raise. It does not drive hardfault_req.
- R4: A fault raised while its enable flag is 0 drives hardfault_req high on the clock edge that samples the raise. Its own fault_req bit stays 0.
- R5: Every bit position not listed in R2 reads as 0, and data written to it is discarded.
- R6: An access at the register offset with bus_priv low changes no flag. It returns bus_rdata of 0 and sets bus_err for one cycle after the access.
- R7: An access at any other offset changes no flag, returns 0 and does not set bus_err.
- R8: When a hardware pending-set event and a software write hit the same pending flag in one cycle, the flag ends up 1.
- R9: exc_enter clears that handler's pending flag and sets its active flag on the same edge.
- R10: exc_return clears that handler's active flag.
- R11: A privileged write updates the flags on the edge that samples it. A privileged read returns the flags as they stood before that edge, on the following cycle. This lets software change one bit through read-modify-write without disturbing the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register port byte address |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | 1 when the access comes from privileged software |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered access error |
| hw_pend_set | input | 4 | Hardware pending-set events, handlers 0 to 3 |
| exc_enter | input | 7 | Exception entry events, handlers 0 to 6 |
| exc_return | input | 7 | Exception return events, handlers 0 to 6 |
| fault_raise | input | 3 | Configurable fault raised, handlers 0 to 2 |
| en_vec | output | 3 | Enable flags |
| pend_vec | output | 4 | Pending flags |
| act_vec | output | 7 | Active flags |
| fault_req | output | 3 | Delivered specific fault requests |
| hardfault_req | output | 1 | Escalated hard-fault request |

## Verification
Every result of this block appears one clock edge after its cause. Flags change on the edge that samples a write or an event, and read data and bus_err are registered on the edge that samples the access. Fault and hard-fault requests are registered on the edge that samples fault_raise. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, so each check lands in the first cycle its result is due. Flag changes are observed through a separate read issued afterwards.

// File: rtl/shc_pkg.sv
package shc_pkg;
  localparam int unsigned N_FLT  = 3;
  localparam int unsigned N_PEND = 4;
  localparam int unsigned N_ACT  = 7;
  localparam int unsigned WORD_W = 32;

  // bit positions software decodes
  localparam int unsigned EN_POS   [N_FLT]  = '{16, 17, 18};
  localparam int unsigned PEND_POS [N_PEND] = '{13, 14, 12, 15};
  localparam int unsigned ACT_POS  [N_ACT]  = '{0, 1, 3, 7, 8, 10, 11};
endpackage

// File: rtl/shc_flag_bank.sv
module shc_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         sw_we,
  input  logic [N-1:0] sw_val,
  output logic [N-1:0] q
);
  // priority per flag: hardware set, hardware clear, software write
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;
      else if (clr_i[i]) q[i] <= 1'b0;
      else if (sw_we)    q[i] <= sw_val[i];
    end
  end
endmodule

// File: rtl/shc_bus_if.sv
module shc_bus_if #(
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              priv,
  output logic              hit_wr,
  output logic              hit_rd,
  output logic              deny
);
  logic here;
  always_comb begin
    here   = (addr == REG_OFFSET);
    hit_wr = here && wr_en && priv;
    hit_rd = here && rd_en && priv;
    deny   = here && (wr_en || rd_en) && !priv;
  end
endmodule

// File: rtl/shc_escalate.sv
module shc_escalate #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raise_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] req_o,
  output logic         hard_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o  <= '0;
      hard_o <= 1'b0;
    end else begin
      req_o  <= raise_i & en_i;
      hard_o <= |(raise_i & ~en_i);
    end
  end
endmodule

// File: rtl/sys_handler_ctrl.sv
module sys_handler_ctrl
  import shc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [WORD_W-1:0]   bus_wdata,
  input  logic                bus_priv,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                bus_err,
  input  logic [N_PEND-1:0]   hw_pend_set,
  input  logic [N_ACT-1:0]    exc_enter,
  input  logic [N_ACT-1:0]    exc_return,
  input  logic [N_FLT-1:0]    fault_raise,
  output logic [N_FLT-1:0]    en_vec,
  output logic [N_PEND-1:0]   pend_vec,
  output logic [N_ACT-1:0]    act_vec,
  output logic [N_FLT-1:0]    fault_req,
  output logic                hardfault_req
);
  logic hit_wr, hit_rd, deny;
  logic [N_FLT-1:0]  w_en;
  logic [N_PEND-1:0] w_pend;
  logic [N_ACT-1:0]  w_act;
  logic [WORD_W-1:0] word;

  shc_bus_if #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_bus (
    .addr(bus_addr), .wr_en(bus_wr_en), .rd_en(bus_rd_en), .priv(bus_priv),
    .hit_wr(hit_wr), .hit_rd(hit_rd), .deny(deny)
  );

  // pick written fields out of the word
  for (genvar i = 0; i < N_FLT; i++) begin : g_wen
    assign w_en[i] = bus_wdata[EN_POS[i]];
  end
  for (genvar i = 0; i < N_PEND; i++) begin : g_wpend
    assign w_pend[i] = bus_wdata[PEND_POS[i]];
  end
  for (genvar i = 0; i < N_ACT; i++) begin : g_wact
    assign w_act[i] = bus_wdata[ACT_POS[i]];
  end

  shc_flag_bank #(.N(N_FLT)) u_en (
    .clk(clk), .rst(rst), .set_i('0), .clr_i('0),
    .sw_we(hit_wr), .sw_val(w_en), .q(en_vec)
  );

  shc_flag_bank #(.N(N_PEND)) u_pend (
    .clk(clk), .rst(rst), .set_i(hw_pend_set), .clr_i(exc_enter[N_PEND-1:0]),
    .sw_we(hit_wr), .sw_val(w_pend), .q(pend_vec)
  );

  shc_flag_bank #(.N(N_ACT)) u_act (
    .clk(clk), .rst(rst), .set_i(exc_enter), .clr_i(exc_return),
    .sw_we(hit_wr), .sw_val(w_act), .q(act_vec)
  );

  shc_escalate #(.N(N_FLT)) u_esc (
    .clk(clk), .rst(rst), .raise_i(fault_raise), .en_i(en_vec),
    .req_o(fault_req), .hard_o(hardfault_req)
  );

  // read word: unassigned positions stay zero
  always_comb begin
    word = '0;
    for (int i = 0; i < N_FLT; i++)  word[EN_POS[i]]   = en_vec[i];
    for (int i = 0; i < N_PEND; i++) word[PEND_POS[i]] = pend_vec[i];
    for (int i = 0; i < N_ACT; i++)  word[ACT_POS[i]]  = act_vec[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= hit_rd ? word : '0;
      bus_err   <= deny;
    end
  end
endmodule

// File: rtl/sys_handler_ctrl_chk.sv
module sys_handler_ctrl_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h24
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_en,
  input logic              bus_rd_en,
  input logic              bus_priv,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic [3:0]        hw_pend_set,
  input logic [6:0]        exc_enter,
  input logic [6:0]        exc_return,
  input logic [2:0]        fault_raise,
  input logic [2:0]        en_vec,
  input logic [3:0]        pend_vec,
  input logic [6:0]        act_vec,
  input logic [2:0]        fault_req,
  input logic              hardfault_req
);
  logic quiet;
  assign quiet = (hw_pend_set == '0) && (exc_enter == '0) && (exc_return == '0);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (en_vec == '0 && pend_vec == '0 && act_vec == '0 && !hardfault_req));

  assert_deliver_R3: assert property (@(posedge clk) disable iff (rst)
    (|(fault_raise & en_vec)) |=> ((fault_req & $past(fault_raise & en_vec)) == $past(fault_raise & en_vec)));

  assert_escalate_R4: assert property (@(posedge clk) disable iff (rst)
    (|(fault_raise & ~en_vec)) |=> (hardfault_req && ((fault_req & $past(fault_raise & ~en_vec)) == '0)));

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & 32'hFFF8_0274) == '0);

  assert_unpriv_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == REG_OFFSET && bus_wr_en && !bus_priv && quiet)
      |=> ($stable(en_vec) && $stable(pend_vec) && $stable(act_vec) && bus_err && bus_rdata == '0));

  assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (|hw_pend_set) |=> ((pend_vec & $past(hw_pend_set)) == $past(hw_pend_set)));

  assert_enter_R9: assert property (@(posedge clk) disable iff (rst)
    ((|exc_enter) && hw_pend_set == '0)
      |=> ((act_vec & $past(exc_enter)) == $past(exc_enter)
           && (pend_vec & $past(exc_enter[3:0])) == '0));

  assert_return_R10: assert property (@(posedge clk) disable iff (rst)
    ((|exc_return) && exc_enter == '0) |=> ((act_vec & $past(exc_return)) == '0));
endmodule

bind sys_handler_ctrl sys_handler_ctrl_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .bus_rd_en(bus_rd_en), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .hw_pend_set(hw_pend_set), .exc_enter(exc_enter),
  .exc_return(exc_return), .fault_raise(fault_raise), .en_vec(en_vec),
  .pend_vec(pend_vec), .act_vec(act_vec), .fault_req(fault_req),
  .hardfault_req(hardfault_req)
);

// File: tb/sys_handler_ctrl_bench.sv
module sys_handler_ctrl_bench;
  localparam int unsigned AW  = 12;
  localparam logic [AW-1:0] OFS = 12'h024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr_en = 1'b0, bus_rd_en = 1'b0, bus_priv = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err;
  logic [3:0] hw_pend_set = '0;
  logic [6:0] exc_enter = '0, exc_return = '0;
  logic [2:0] fault_raise = '0;
  logic [2:0] en_vec, fault_req;
  logic [3:0] pend_vec;
  logic [6:0] act_vec;
  logic hardfault_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sys_handler_ctrl #(.ADDR_W(AW), .REG_OFFSET(OFS)) u_sys_handler_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .hw_pend_set(hw_pend_set),
    .exc_enter(exc_enter), .exc_return(exc_return), .fault_raise(fault_raise),
    .en_vec(en_vec), .pend_vec(pend_vec), .act_vec(act_vec),
    .fault_req(fault_req), .hardfault_req(hardfault_req)
  );

  // {enable[2:0], raise[2:0], expected fault_req[2:0], expected hardfault}
  localparam logic [9:0] VEC [8] = '{
    {3'b000, 3'b001, 3'b000, 1'b1},
    {3'b001, 3'b001, 3'b001, 1'b0},
    {3'b000, 3'b010, 3'b000, 1'b1},
    {3'b010, 3'b010, 3'b010, 1'b0},
    {3'b000, 3'b100, 3'b000, 1'b1},
    {3'b100, 3'b100, 3'b100, 1'b0},
    {3'b011, 3'b111, 3'b011, 1'b1},
    {3'b111, 3'b000, 3'b000, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [AW-1:0] a, input logic wr, input logic [31:0] d,
                        input logic priv, output logic [31:0] rd, output logic err);
    @(negedge clk);
    bus_addr = a; bus_wr_en = wr; bus_rd_en = !wr; bus_wdata = d; bus_priv = priv;
    @(posedge clk); #1;
    rd = bus_rdata; err = bus_err;
    bus_wr_en = 1'b0; bus_rd_en = 1'b0;
  endtask

  function automatic logic [31:0] en_word(input logic [2:0] e);
    return {13'd0, e, 16'd0};
  endfunction

  initial begin
    logic [31:0] rd, v;
    logic err;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    access(OFS, 1'b0, '0, 1'b1, rd, err);
    check("R1 reset read", rd, 32'h0);
    check("R1 reset vectors", {14'd0, en_vec, pend_vec, act_vec, fault_req, hardfault_req}, 32'h0);

    // R3 R4 escalation table
    for (int k = 0; k < 8; k++) begin
      access(OFS, 1'b1, en_word(VEC[k][9:7]), 1'b1, rd, err);
      @(negedge clk); fault_raise = VEC[k][6:4];
      @(posedge clk); #1;
      check("R3 R4 fault_req", {29'd0, fault_req}, {29'd0, VEC[k][3:1]});
      check("R3 R4 hardfault_req", {31'd0, hardfault_req}, {31'd0, VEC[k][0]});
      fault_raise = '0;
    end

    // R5 reserved positions
    access(OFS, 1'b1, 32'hFFFF_FFFF, 1'b1, rd, err);
    access(OFS, 1'b0, '0, 1'b1, rd, err);
    check("R5 reserved masked", rd, 32'h0007_FD8B);
    check("R2 vectors mirror", {18'd0, en_vec, pend_vec, act_vec}, {18'd0, 3'b111, 4'hF, 7'h7F});

    // R11 read-modify-write
    access(OFS, 1'b1, 32'h0003_0089, 1'b1, rd, err);
    access(OFS, 1'b0, '0, 1'b1, rd, err);
    check("R2 layout read", rd, 32'h0003_0089);
    v = rd | 32'h0000_0400;
    access(OFS, 1'b1, v, 1'b1, rd, err);
    access(OFS, 1'b0, '0, 1'b1, rd, err);
    check("R11 rmw set PendSV active", rd, 32'h0003_0489);
    v = rd & ~32'h0001_0000;
    access(OFS, 1'b1, v, 1'b1, rd, err);
    access(OFS, 1'b0, '0, 1'b1, rd, err);
    check("R11 rmw clear memory enable", rd, 32'h0002_0489);

    // R6 unprivileged access
    access(OFS, 1'b1, 32'h0, 1'b0, rd, err);
    check("R6 unpriv write err", {31'd0, err}, 32'd1);
    access(OFS, 1'b0, '0, 1'b0, rd, err);
    check("R6 unpriv read data", rd, 32'h0);
    check("R6 unpriv read err", {31'd0, err}, 32'd1);
    access(OFS, 1'b0, '0, 1'b1, rd, err);
    check("R6 state kept", rd, 32'h0002_0489);
    check("R6 err drops", {31'd0, err}, 32'd0);

    // R7 other offset
    access(12'h020, 1'b1, 32'hFFFF_FFFF, 1'b1, rd, err);
    check("R7 no err", {31'd0, err}, 32'd0);
    access(12'h020, 1'b0, '0, 1'b1, rd, err);
    check("R7 other read zero", rd, 32'h0);
    access(OFS, 1'b0, '0, 1'b1, rd, err);
    check("R7 state kept", rd, 32'h0002_0489);

    // R8 hardware set beats software clear (SVC pending, bit 15)
    @(negedge clk);
    bus_addr = OFS; bus_wr_en = 1'b1; bus_wdata = 32'h0; bus_priv = 1'b1;
    hw_pend_set = 4'b1000;
    @(posedge clk); #1;
    bus_wr_en = 1'b0; hw_pend_set = '0;
    access(OFS, 1'b0, '0, 1'b1, rd, err);
    check("R8 hw set wins", rd, 32'h0000_8000);

    // R9 entry, R10 return on bus fault
    @(negedge clk); hw_pend_set = 4'b0010;
    @(posedge clk); #1; hw_pend_set = '0;
    access(OFS, 1'b0, '0, 1'b1, rd, err);
    check("R9 bus pending set", rd, 32'h0000_C000);
    @(negedge clk); exc_enter = 7'b0000010;
    @(posedge clk); #1; exc_enter = '0;
    check("R9 entry vectors", {21'd0, pend_vec, act_vec}, {21'd0, 4'b1000, 7'b0000010});
    access(OFS, 1'b0, '0, 1'b1, rd, err);
    check("R9 entry read", rd, 32'h0000_8002);
    @(negedge clk); exc_return = 7'b0000010;
    @(posedge clk); #1; exc_return = '0;
    access(OFS, 1'b0, '0, 1'b1, rd, err);
    check("R10 return clears active", rd, 32'h0000_8000);

    // R1 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset clears pending", {28'd0, pend_vec}, 32'h0);
    @(negedge clk); rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule